// File: doc/BRIEF.md
# Masked Interrupt Request Aggregator

This block gathers up to eight device interrupt sources into one request line for a higher-level interrupt controller. A pending register records which sources have raised a request. An enable register decides which pending sources may reach the output. Devices change the pending register directly with bit-vector set and clear strobes. Software reaches the block through three byte-wide register selects: a mask register, an acknowledge register and a status register.

The mask register has inverted polarity. A one written to a mask bit blocks that source and a zero lets it through, and a read returns the same inverted view. An acknowledge write names a single source by index and clears only that pending bit. The combined request is the OR of the enabled pending bits. An interrupting flag follows that request, so the block gives one pulse when the request appears and one pulse when it goes away, and it pulses on no other cycle.

Top module: `irq_mask_aggr`

## Requirements
- R1: After reset the pending and enable registers hold zero, `irq_level`, `irq_assert` and `irq_deassert` are low, and a mask read (`rd_sel` = 0) returns 0xFF.
- R2: A write with `wr_sel` = 0 stores the bitwise complement of `wr_data` as the enable set. A later mask read (`rd_sel` = 0) returns the complement of the enable set, which equals the value that was written.
- R3: A read with `rd_sel` = 2 returns the pending register on bits 7:0 with bits 63:8 at zero. Reads with `rd_sel` = 1 or 3 return zero.
- R4: Every bit set in `src_set` becomes set in the pending register at the next clock edge, unless the same edge clears that bit.
- R5: Every bit set in `src_clr` is zero in the pending register after the clock edge. When `src_set` and `src_clr` name the same bit on one edge, the clear wins.
- R6: A write with `wr_sel` = 1 clears the pending bit whose index is `wr_data[3:0]`. `wr_data[7:4]` is ignored. An index of 8 or higher changes nothing.
- R7: `irq_level` is the OR over all bits of (pending AND enable), taken from the registered state right after each clock edge.
- R8: `irq_assert` is high for exactly one cycle after `irq_level` goes from 0 to 1, and `irq_deassert` is high for exactly one cycle after it goes from 1 to 0. Neither pulses while `irq_level` keeps its value, even when the mask or the pending bits change. The two pulses are never high together.
- R9: Writes with `wr_sel` = 2 or `wr_sel` = 3 change neither the pending nor the enable register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 mask, 1 acknowledge, 2 status (ignored), 3 none |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Read target: 0 mask, 2 status, others read zero |
| rd_data | output | 64 | Combinational read data, zero-extended |
| src_set | input | 8 | Per-source set strobes |
| src_clr | input | 8 | Per-source clear strobes |
| irq_level | output | 1 | Combined request level |
| irq_assert | output | 1 | One-cycle pulse when the request appears |
| irq_deassert | output | 1 | One-cycle pulse when the request goes away |

## Verification
The hardest case to reach is a mask or pending change that keeps the combined request at the same value. An edge tracker that reacts to register activity instead of to level changes would pulse wrongly only in that case. The stimulus sweeps every pending pattern against sixteen mask values, clearing and refilling the pending register each time. Many of these steps change the mask while the level stays put, and a reference model computes the expected pulses cycle by cycle. Acknowledge writes are swept over every index and every upper-nibble value, including indices beyond the source count.

// File: rtl/irq_aggr_pkg.sv
`timescale 1ns/1ps
package irq_aggr_pkg;
  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_ACK  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_pend_reg.sv
`timescale 1ns/1ps
module irq_pend_reg #(
  parameter int unsigned N    = 8,
  parameter int unsigned IDXW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    set_vec,
  input  logic [N-1:0]    clr_vec,
  input  logic            ack_fire,
  input  logic [IDXW-1:0] ack_idx,
  output logic [N-1:0]    ack_vec,
  output logic [N-1:0]    pend_q
);
  // one-hot of the acknowledged index, empty when the index is out of range
  function automatic logic [N-1:0] ack_decode(input logic fire, input logic [IDXW-1:0] idx);
    logic [N-1:0] v;
    v = '0;
    for (int i = 0; i < N; i++) begin
      if (fire && (int'(idx) == i)) v[i] = 1'b1;
    end
    return v;
  endfunction

  // clears, from strobe or acknowledge, take precedence over sets
  function automatic logic [N-1:0] pend_next(input logic [N-1:0] cur, input logic [N-1:0] s,
                                             input logic [N-1:0] c, input logic [N-1:0] a);
    return (cur | s) & ~c & ~a;
  endfunction

  assign ack_vec = ack_decode(ack_fire, ack_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_next(pend_q, set_vec, clr_vec, ack_vec);
  end
endmodule

// File: rtl/irq_mask_reg.sv
`timescale 1ns/1ps
module irq_mask_reg #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] en_q,
  output logic [N-1:0] mask_view
);
  // the software view is the inverse of the stored enables
  function automatic logic [N-1:0] flip(input logic [N-1:0] v);
    return ~v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  en_q <= '0;
    else if (wr) en_q <= flip(wdata);
  end

  assign mask_view = flip(en_q);
endmodule

// File: rtl/irq_edge_track.sv
`timescale 1ns/1ps
module irq_edge_track (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise_evt,
  output logic fall_evt
);
  logic busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= level;
  end

  assign rise_evt = level & ~busy_q;
  assign fall_evt = ~level & busy_q;
endmodule

// File: rtl/irq_mask_aggr.sv
`timescale 1ns/1ps
module irq_mask_aggr #(
  parameter int unsigned N      = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDXW   = 4,
  parameter int unsigned RD_W   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [RD_W-1:0]   rd_data,
  input  logic [N-1:0]      src_set,
  input  logic [N-1:0]      src_clr,
  output logic              irq_level,
  output logic              irq_assert,
  output logic              irq_deassert
);
  import irq_aggr_pkg::*;

  localparam int unsigned PADW = RD_W - N;

  function automatic logic [RD_W-1:0] zext(input logic [N-1:0] v);
    return {{PADW{1'b0}}, v};
  endfunction

  logic         wr_mask;
  logic         wr_ack;
  logic [N-1:0] pend_q;
  logic [N-1:0] en_q;
  logic [N-1:0] ack_vec;
  logic [N-1:0] mask_view;
  logic [N-1:0] live;

  assign wr_mask = wr_en && (reg_sel_e'(wr_sel) == SEL_MASK);
  assign wr_ack  = wr_en && (reg_sel_e'(wr_sel) == SEL_ACK);

  irq_pend_reg #(.N(N), .IDXW(IDXW)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_vec(src_set), .clr_vec(src_clr),
    .ack_fire(wr_ack), .ack_idx(wr_data[IDXW-1:0]),
    .ack_vec(ack_vec), .pend_q(pend_q)
  );

  irq_mask_reg #(.N(N)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr(wr_mask), .wdata(wr_data[N-1:0]),
    .en_q(en_q), .mask_view(mask_view)
  );

  assign live      = pend_q & en_q;
  assign irq_level = |live;

  irq_edge_track u_edge (
    .clk(clk), .rst_n(rst_n), .level(irq_level),
    .rise_evt(irq_assert), .fall_evt(irq_deassert)
  );

  always_comb begin
    case (reg_sel_e'(rd_sel))
      SEL_MASK: rd_data = zext(mask_view);
      SEL_STAT: rd_data = zext(pend_q);
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/irq_mask_aggr_chk.sv
`timescale 1ns/1ps
module irq_mask_aggr_chk #(
  parameter int unsigned N      = 8,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic [N-1:0]      src_set,
  input logic [N-1:0]      src_clr,
  input logic [N-1:0]      pend_q,
  input logic [N-1:0]      en_q,
  input logic [N-1:0]      ack_vec,
  input logic              irq_level,
  input logic              irq_assert,
  input logic              irq_deassert
);
  a_r2_mask_inverted: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'd0) |=> (en_q == ~$past(wr_data[N-1:0])));

  a_r4_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_set) |=> ((pend_q & $past(src_set & ~src_clr & ~ack_vec)) == $past(src_set & ~src_clr & ~ack_vec)));

  a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_clr) |=> ((pend_q & $past(src_clr)) == '0));

  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack_vec) |=> ((pend_q & $past(ack_vec)) == '0));

  a_r6_ack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_vec));

  a_r8_rise_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_assert == $rose(irq_level));

  a_r8_fall_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_deassert == $fell(irq_level));

  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_assert && irq_deassert));

  a_r9_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_sel == 2'd0) |=> $stable(en_q));
endmodule

bind irq_mask_aggr irq_mask_aggr_chk #(.N(N), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .src_set(src_set), .src_clr(src_clr), .pend_q(pend_q), .en_q(en_q),
  .ack_vec(ack_vec), .irq_level(irq_level), .irq_assert(irq_assert),
  .irq_deassert(irq_deassert)
);

// File: tb/irq_mask_aggr_tb.sv
`timescale 1ns/1ps
module irq_mask_aggr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd3;
  logic [7:0]  wr_data = 8'h00;
  logic [1:0]  rd_sel = 2'd3;
  logic [63:0] rd_data;
  logic [7:0]  src_set = 8'h00;
  logic [7:0]  src_clr = 8'h00;
  logic        irq_level, irq_assert, irq_deassert;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  logic [7:0] m_pend = 8'h00;
  logic [7:0] m_en   = 8'h00;
  logic       m_prev = 1'b0;

  always #2.5 clk = ~clk;

  irq_mask_aggr u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .src_set(src_set), .src_clr(src_clr),
    .irq_level(irq_level), .irq_assert(irq_assert), .irq_deassert(irq_deassert)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock of stimulus; the model advances and the outputs are compared 1 ns after the edge
  task automatic step(input logic we, input logic [1:0] sel, input logic [7:0] d,
                      input logic [7:0] s, input logic [7:0] c);
    logic lvl;
    @(negedge clk);
    wr_en = we; wr_sel = sel; wr_data = d; src_set = s; src_clr = c;
    @(posedge clk);
    #1;
    for (int b = 0; b < 8; b++) begin
      if (s[b]) m_pend[b] = 1'b1;
      if (c[b]) m_pend[b] = 1'b0;
    end
    if (we && sel == 2'd1 && d[3:0] < 4'd8) m_pend[d[3:0]] = 1'b0;
    if (we && sel == 2'd0) m_en = 8'hFF ^ d;
    lvl = 1'b0;
    for (int b = 0; b < 8; b++) lvl = lvl | (m_pend[b] & m_en[b]);
    chk("R7 level", {63'd0, irq_level}, {63'd0, lvl});
    chk("R8 assert", {63'd0, irq_assert}, {63'd0, lvl && !m_prev});
    chk("R8 deassert", {63'd0, irq_deassert}, {63'd0, !lvl && m_prev});
    m_prev = lvl;
    wr_en = 1'b0; wr_sel = 2'd3; wr_data = 8'h00; src_set = 8'h00; src_clr = 8'h00;
  endtask

  task automatic rd(input string req, input logic [1:0] sel, input logic [63:0] exp);
    rd_sel = sel;
    #0.2;
    chk(req, rd_data, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 level", {63'd0, irq_level}, 64'd0);
    chk("R1 pulses", {62'd0, irq_assert, irq_deassert}, 64'd0);
    rd("R1 mask read", 2'd0, 64'hFF);
    rd("R1 status read", 2'd2, 64'h0);
    @(negedge clk); rst_n = 1'b1;

    // R2 R3 R4 R7 R8: every pending pattern against sixteen mask values
    for (int p = 0; p < 256; p++) begin
      for (int k = 0; k < 16; k++) begin
        logic [7:0] mv;
        mv = 8'(k * 37 + 3);
        step(1'b0, 2'd3, 8'h00, 8'h00, 8'hFF);
        step(1'b0, 2'd3, 8'h00, 8'(p), 8'h00);
        step(1'b1, 2'd0, mv, 8'h00, 8'h00);
        rd("R3 status", 2'd2, {56'd0, 8'(p)});
        rd("R2 mask read", 2'd0, {56'd0, mv});
      end
    end

    // R3 other selects read zero
    step(1'b0, 2'd3, 8'h00, 8'hFF, 8'h00);
    rd("R3 ack read", 2'd1, 64'd0);
    rd("R3 none read", 2'd3, 64'd0);

    // R6 acknowledge over every index and upper nibble
    step(1'b1, 2'd0, 8'h00, 8'h00, 8'h00);
    for (int idx = 0; idx < 16; idx++) begin
      for (int up = 0; up < 16; up++) begin
        logic [7:0] e;
        step(1'b0, 2'd3, 8'h00, 8'hFF, 8'h00);
        step(1'b1, 2'd1, {4'(up), 4'(idx)}, 8'h00, 8'h00);
        e = 8'hFF;
        if (idx < 8) e = e & ~(8'h01 << idx);
        rd("R6 ack", 2'd2, {56'd0, e});
      end
    end

    // R5 clear wins over set on the same edge
    step(1'b0, 2'd3, 8'h00, 8'h00, 8'hFF);
    step(1'b0, 2'd3, 8'h00, 8'hAA, 8'h0F);
    rd("R5 clear wins", 2'd2, 64'hA0);

    // R9 writes to status and unused selects are ignored
    step(1'b1, 2'd0, 8'h5A, 8'h00, 8'h00);
    step(1'b1, 2'd2, 8'h00, 8'h00, 8'h00);
    step(1'b1, 2'd3, 8'hFF, 8'h00, 8'h00);
    rd("R9 status kept", 2'd2, 64'hA0);
    rd("R9 mask kept", 2'd0, 64'h5A);

    // R8 mask swap that keeps the level high gives no pulse
    step(1'b0, 2'd3, 8'h00, 8'h03, 8'hFC);
    step(1'b1, 2'd0, 8'hFE, 8'h00, 8'h00);
    step(1'b1, 2'd0, 8'hFD, 8'h00, 8'h00);
    chk("R8 no pulse on steady level", {62'd0, irq_assert, irq_deassert}, 64'd0);
    step(1'b1, 2'd1, 8'h01, 8'h00, 8'h00);
    chk("R8 deassert after ack", {63'd0, irq_deassert}, 64'd1);
    step(1'b0, 2'd3, 8'h00, 8'h00, 8'h00);
    chk("R8 pulse is one cycle", {63'd0, irq_deassert}, 64'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule